// File: doc/BRIEF.md
# Wear-Levelled Append-Only Word Store

This block holds the most recent 16-bit value in a page of 32 halfword slots. The slots have erase-to-all-ones semantics: an erased slot reads 0xFFFF, and that value means the slot is empty. A new value is never written over an older one. It goes into the lowest empty slot, so each slot is programmed at most once between erases. The whole page is erased only when no empty slot is left, and the value then lands in slot 0. A read returns the newest value, which is the highest-indexed slot that is not 0xFFFF.

A request is a one-cycle `op_start` pulse with a code on `op_sel`. The block scans one slot per clock. It holds `busy` while it works and ends every request with a one-cycle `done` pulse, with the result on `status`. After programming a slot, the block reads it back and compares. After an erase, it checks that every slot is blank. An initialise request erases the page only if the page already looks blank; otherwise it leaves the contents alone.

Reset models a freshly erased page: all slots read 0xFFFF. The value 0xFFFF may be written, but it cannot be told apart from an empty slot.

Top module: `wear_slot_store`

## Requirements
- R1: While and after reset, `busy` and `done` are 0, `status` is 0, `rd_data` is 0xFFFF, and every slot is erased.
- R2: A write (`op_sel`=1) stores `wr_data` in the lowest-indexed slot holding 0xFFFF. When that slot is k, `done` rises after k+4 rising edges, counting the edge that samples `op_start` as the first.
- R3: A read (`op_sel`=0) scans from slot 31 down. It puts the first value that is not 0xFFFF on `rd_data`, or 0xFFFF if all slots are blank. With the found slot k (k=0 for a blank page), `done` rises after 33-k edges. `rd_data` changes only in the `done` cycle of a read.
- R4: A write to a full page erases all slots and then stores the value in slot 0, with `done` after 68 edges. Afterwards, the written value is the only non-blank entry.
- R5: `status` encoding: 0 OK, 1 request error, 2 erase error, 3 verify error. A write whose read-back matches reports 0. A write never reports 1.
- R6: An initialise request (`op_sel`=2) on an all-blank page erases it and reports 0 after 66 edges. On a page whose first non-blank slot is j, it reports 0 after j+2 edges and changes no slot.
- R7: `op_sel`=3 is rejected with `status`=1 and `done` after 1 edge. No slot and no `rd_data` bit changes.
- R8: `op_start` is ignored while `busy` is high. It does not change the running request, its timing, or the stored data.
- R9: `done` lasts exactly one cycle, and `busy` is 0 whenever `done` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; blanks the page |
| op_start | input | 1 | Request pulse, sampled when idle |
| op_sel | input | 2 | Request code: 0 read, 1 write, 2 initialise, 3 reserved |
| wr_data | input | 16 | Value to append on a write |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Newest stored value from the last read |
| status | output | 2 | Result code of the last request |

## Verification
The bench fills the page one slot at a time and reads back after every write. The read must return the value just written, and the latency of both the write and the read must match the slot index. A design that appended to the wrong slot, or scanned the wrong way, would miss on value or timing. The 33rd write must erase and restart at slot 0: a design that erased too early, or failed to clear, would leave a stale value visible to the next read. Initialise is applied to a blank page and to a filled page, to catch a design that wipes live data. The reserved code and starts raised while busy are applied between known writes; a design that acted on them would show changed read data or altered timing.

// File: rtl/wear_slot_store.sv
module wear_slot_store #(
  parameter int WORD_W = 16,
  parameter int SLOTS  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start,
  input  logic [1:0]        op_sel,
  input  logic [WORD_W-1:0] wr_data,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rd_data,
  output logic [1:0]        status
);
  localparam int IDX_W = $clog2(SLOTS);
  localparam logic [WORD_W-1:0] BLANK = '1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);
  localparam logic [1:0] ST_OK = 2'd0, ST_REQ = 2'd1, ST_ERS = 2'd2, ST_VFY = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_FIND, S_CHECK, S_ERASE, S_EVER, S_PROG, S_PVER, S_BACK, S_FIN
  } state_t;

  state_t            st;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] val;
  logic              is_init;
  logic [WORD_W-1:0] page [SLOTS];
  logic [WORD_W-1:0] cur;
  logic              cur_blank, at_last, at_first;

  assign cur       = page[idx];
  assign cur_blank = (cur == BLANK);
  assign at_last   = (idx == LAST);
  assign at_first  = (idx == '0);
  assign busy      = (st != S_IDLE) && (st != S_FIN);
  assign done      = (st == S_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) page[i] <= BLANK;
    end else if (st == S_ERASE) begin
      for (int i = 0; i < SLOTS; i++) page[i] <= BLANK;
    end else if (st == S_PROG) begin
      page[idx] <= val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      idx     <= '0;
      val     <= '0;
      is_init <= 1'b0;
      status  <= ST_OK;
      rd_data <= BLANK;
    end else begin
      case (st)
        S_IDLE: if (op_start) begin
          idx     <= '0;
          is_init <= (op_sel == 2'd2);
          case (op_sel)
            2'd0: begin idx <= LAST; st <= S_BACK; end
            2'd1: begin val <= wr_data; st <= S_FIND; end
            2'd2: st <= S_CHECK;
            default: begin status <= ST_REQ; st <= S_FIN; end
          endcase
        end
        S_FIND:
          if (cur_blank)    st <= S_PROG;
          else if (at_last) st <= S_ERASE;
          else              idx <= idx + IDX_W'(1);
        S_CHECK:
          if (!cur_blank)   begin status <= ST_OK; st <= S_FIN; end
          else if (at_last) st <= S_ERASE;
          else              idx <= idx + IDX_W'(1);
        S_ERASE: begin idx <= '0; st <= S_EVER; end
        S_EVER:
          if (!cur_blank) begin status <= ST_ERS; st <= S_FIN; end
          else if (at_last) begin
            idx <= '0;
            if (is_init) begin status <= ST_OK; st <= S_FIN; end
            else st <= S_PROG;
          end else idx <= idx + IDX_W'(1);
        S_PROG: st <= S_PVER;
        S_PVER: begin
          status <= (cur == val) ? ST_OK : ST_VFY;
          st     <= S_FIN;
        end
        S_BACK:
          if (!cur_blank || at_first) begin
            rd_data <= cur;
            status  <= ST_OK;
            st      <= S_FIN;
          end else idx <= idx - IDX_W'(1);
        default: st <= S_IDLE;
      endcase
    end
  end

  p_prog_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PROG) |-> cur_blank);
  p_rd_on_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> done);
  p_erase_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ERASE && !is_init) |-> ($past(st) == S_FIND && $past(idx) == LAST));
  p_wr_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PVER) |=> (status == ST_OK || status == ST_VFY));
  p_req_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == ST_REQ) |-> $past(st) == S_IDLE);
  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && op_start) |=> (busy || done));
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/test_wear_slot_store.sv
module test_wear_slot_store;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_start = 1'b0;
  logic [1:0]  op_sel = 2'd0;
  logic [15:0] wr_data = 16'h0;
  logic        busy, done;
  logic [15:0] rd_data;
  logic [1:0]  status;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  wear_slot_store i_wear_slot_store (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_sel(op_sel),
    .wr_data(wr_data), .busy(busy), .done(done), .rd_data(rd_data), .status(status)
  );

  function automatic logic [15:0] pat(input int i);
    return 16'h1000 + 16'(i) * 16'h0123;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      op_start = 1'b0;
    end while (!done && lat < 500);
    chk("R9 busy low with done", int'(busy), 0);
    @(negedge clk);
    chk("R9 done one cycle", int'(done), 0);
  endtask

  task automatic run_op(input logic [1:0] op, input logic [15:0] d, output int lat);
    @(negedge clk);
    op_start = 1'b1;
    op_sel   = op;
    wr_data  = d;
    wait_done(lat);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 status", int'(status), 0);
    chk("R1 rd_data", int'(rd_data), 16'hFFFF);
    rst_n = 1'b1;

    run_op(2'd0, 16'h0, lat);
    chk("R1 R3 blank read value", int'(rd_data), 16'hFFFF);
    chk("R3 blank read latency", lat, 33);

    run_op(2'd2, 16'h0, lat);
    chk("R6 init blank status", int'(status), 0);
    chk("R6 init blank latency", lat, 66);

    for (int i = 0; i < 32; i++) begin
      run_op(2'd1, pat(i), lat);
      chk("R2 write latency", lat, i + 4);
      chk("R5 write status", int'(status), 0);
      run_op(2'd0, 16'h0, lat);
      chk("R3 read value", int'(rd_data), int'(pat(i)));
      chk("R3 read latency", lat, 33 - i);
    end

    run_op(2'd1, pat(32), lat);
    chk("R4 wrap latency", lat, 68);
    chk("R4 wrap status", int'(status), 0);
    run_op(2'd0, 16'h0, lat);
    chk("R4 read after wrap", int'(rd_data), int'(pat(32)));
    chk("R4 only slot 0 used", lat, 33);

    run_op(2'd1, pat(33), lat);
    chk("R2 R4 append after wrap", lat, 5);

    run_op(2'd2, 16'h0, lat);
    chk("R6 init live latency", lat, 2);
    chk("R6 init live status", int'(status), 0);
    run_op(2'd0, 16'h0, lat);
    chk("R6 contents kept", int'(rd_data), int'(pat(33)));
    chk("R6 contents kept latency", lat, 32);

    run_op(2'd3, 16'h7777, lat);
    chk("R7 reserved status", int'(status), 1);
    chk("R7 reserved latency", lat, 1);
    chk("R7 rd_data unchanged", int'(rd_data), int'(pat(33)));
    run_op(2'd0, 16'h0, lat);
    chk("R7 page unchanged", int'(rd_data), int'(pat(33)));
    chk("R7 page unchanged latency", lat, 32);

    @(negedge clk);
    op_start = 1'b1; op_sel = 2'd1; wr_data = 16'hA5A5;
    @(negedge clk);
    op_sel = 2'd1; wr_data = 16'h5A5A;
    @(negedge clk);
    op_sel = 2'd3;
    @(negedge clk);
    op_start = 1'b0;
    lat = 3;
    while (!done && lat < 500) begin
      @(negedge clk);
      lat++;
    end
    chk("R8 write timing kept", lat, 6);
    chk("R8 status kept", int'(status), 0);
    @(negedge clk);
    run_op(2'd0, 16'h0, lat);
    chk("R8 stored value", int'(rd_data), 16'hA5A5);
    chk("R8 slot 2 used", lat, 31);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule